// File: doc/BRIEF.md
# Exception Entry Sequencer

This block carries out the architectural state change that happens when a processor core takes an exception. Seven request lines arrive, one per exception source. The block also receives the return address that the core wants preserved and the current program status word. In one clock step the block selects the winning source, applying a fixed priority. Requests from the normal and fast interrupt lines are dropped while their disable bits are set in the current status word.

For the winning source, the block presents a single registered write bundle. The bundle holds the value for the banked link register of the target mode, the value for the banked saved-status register, the rewritten status word, and the vector address that the program counter jumps to. Neighbouring logic performs the register-file writes and handles exception return. This block only forms the values and flags them valid.

The request line positions are: bit 0 reset, bit 1 undefined instruction, bit 2 supervisor call, bit 3 prefetch abort, bit 4 data abort, bit 5 normal interrupt (irq), bit 6 fast interrupt (fiq). The same index is reported on `exc_kind`. The status word bits are: mode field [4:0], T bit 5, F bit 6, I bit 7, J bit 24.

Top module: `exc_entry_seq`

## Requirements
- R1: When at least one unmasked request line is high at a rising clock edge, `wr_valid` is 1 after that edge, and `exc_kind` gives the index of the winning source. With no unmasked request, `wr_valid` is 0 after the edge.
- R2: `lr_data` equals the `ret_pc` sampled at the same edge as the request.
- R3: `spsr_data` equals the `cur_psr` sampled at the same edge as the request.
- R4: `new_psr` is `cur_psr` with T (bit 5) cleared, J (bit 24) cleared, I (bit 7) set, and the mode field [4:0] replaced. All other bits are unchanged.
- R5: F (bit 6) of `new_psr` is set for the reset and fiq sources. For every other source it keeps its value from `cur_psr`.
- R6: `new_pc` is the vector of the winning source: reset 0x00, undefined 0x04, supervisor call 0x08, prefetch abort 0x0C, data abort 0x10, irq 0x18, fiq 0x1C.
- R7: The mode field of `new_psr` is: fiq 10001, irq 10010, reset and supervisor call 10011, both aborts 10111, undefined 11011.
- R8: When several unmasked requests are high together, the winner is chosen in this order, highest first: reset, data abort, fiq, irq, prefetch abort, undefined, supervisor call.
- R9: The irq line is ignored while I (bit 7) of `cur_psr` is 1. It then neither produces a write nor blocks a lower-priority request.
- R10: The fiq line is ignored while F (bit 6) of `cur_psr` is 1. It then neither produces a write nor blocks a lower-priority request.
- R11: While `rst` is high at a clock edge, after that edge `wr_valid` is 0 and all data outputs are 0. The reset request line is never masked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| exc_req | input | 7 | One request line per exception source |
| ret_pc | input | 32 | Return address to preserve |
| cur_psr | input | 32 | Current program status word |
| wr_valid | output | 1 | Write bundle valid this cycle |
| exc_kind | output | 3 | Index of the source taken |
| lr_data | output | 32 | Value for the banked link register |
| spsr_data | output | 32 | Value for the banked saved-status register |
| new_psr | output | 32 | Rewritten status word |
| new_pc | output | 32 | Vector address for the program counter |

## Verification
Each source is first raised alone. Its input status word has T, J, I and F in contrasting settings, so that a missing clear, a missing set or a wrong mode code shows up. Pairs and full sets of simultaneous requests then separate every adjacent pair in the priority order. Masked interrupt lines are raised beside a lower-priority request; this tells "masked and skipped" apart from "masked but still blocking". A final all-masked case checks that nothing is written. Distinct return addresses and status words are used in each case, so that stale or swapped data is exposed.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

    localparam int NUM_SRC   = 7;
    localparam int XLEN      = 32;
    localparam int KIND_W    = $clog2(NUM_SRC);
    localparam int MODE_W    = 5;

    localparam int PSR_T_BIT = 5;
    localparam int PSR_F_BIT = 6;
    localparam int PSR_I_BIT = 7;
    localparam int PSR_J_BIT = 24;

    typedef enum logic [KIND_W-1:0] {
        SRC_RST  = 3'd0,
        SRC_UND  = 3'd1,
        SRC_SVC  = 3'd2,
        SRC_PABT = 3'd3,
        SRC_DABT = 3'd4,
        SRC_IRQ  = 3'd5,
        SRC_FIQ  = 3'd6
    } exc_src_e;

    typedef struct packed {
        logic [XLEN-1:0] lr;
        logic [XLEN-1:0] spsr;
        logic [XLEN-1:0] psr;
        logic [XLEN-1:0] pc;
        exc_src_e        src;
    } exc_entry_t;

    // Rank 0 is the most urgent source.
    function automatic exc_src_e src_at_rank(input int rank);
        case (rank)
            0:       return SRC_RST;
            1:       return SRC_DABT;
            2:       return SRC_FIQ;
            3:       return SRC_IRQ;
            4:       return SRC_PABT;
            5:       return SRC_UND;
            default: return SRC_SVC;
        endcase
    endfunction

    function automatic logic [XLEN-1:0] vector_of(input exc_src_e s);
        case (s)
            SRC_RST:  return 32'h0000_0000;
            SRC_UND:  return 32'h0000_0004;
            SRC_SVC:  return 32'h0000_0008;
            SRC_PABT: return 32'h0000_000C;
            SRC_DABT: return 32'h0000_0010;
            SRC_IRQ:  return 32'h0000_0018;
            default:  return 32'h0000_001C;
        endcase
    endfunction

    function automatic logic [MODE_W-1:0] mode_of(input exc_src_e s);
        case (s)
            SRC_FIQ:            return 5'b10001;
            SRC_IRQ:            return 5'b10010;
            SRC_PABT, SRC_DABT: return 5'b10111;
            SRC_UND:            return 5'b11011;
            default:            return 5'b10011;
        endcase
    endfunction

endpackage

// File: rtl/exc_seq_arb.sv
module exc_seq_arb
    import exc_seq_pkg::*;
(
    input  logic [NUM_SRC-1:0] req,
    input  logic               irq_off,
    input  logic               fiq_off,
    output logic               hit,
    output exc_src_e           win
);
    logic [NUM_SRC-1:0] live;

    // Per-source gating: only the two interrupt lines have a disable bit.
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_gate
        if (g == int'(SRC_IRQ)) begin : g_irq
            assign live[g] = req[g] & ~irq_off;
        end else if (g == int'(SRC_FIQ)) begin : g_fiq
            assign live[g] = req[g] & ~fiq_off;
        end else begin : g_plain
            assign live[g] = req[g];
        end
    end

    // Walk from least to most urgent so the most urgent live source wins.
    always_comb begin
        win = SRC_SVC;
        for (int r = NUM_SRC - 1; r >= 0; r--) begin
            if (live[int'(src_at_rank(r))]) win = src_at_rank(r);
        end
    end

    assign hit = |live;
endmodule

// File: rtl/exc_seq_psr.sv
module exc_seq_psr
    import exc_seq_pkg::*;
(
    input  logic [XLEN-1:0] old_psr,
    input  exc_src_e        src,
    output logic [XLEN-1:0] upd_psr
);
    always_comb begin
        upd_psr               = old_psr;
        upd_psr[PSR_T_BIT]    = 1'b0;
        upd_psr[PSR_J_BIT]    = 1'b0;
        upd_psr[PSR_I_BIT]    = 1'b1;
        if (src == SRC_FIQ || src == SRC_RST) upd_psr[PSR_F_BIT] = 1'b1;
        upd_psr[MODE_W-1:0]   = mode_of(src);
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_seq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_SRC-1:0]    exc_req,
    input  logic [XLEN-1:0]       ret_pc,
    input  logic [XLEN-1:0]       cur_psr,
    output logic                  wr_valid,
    output logic [KIND_W-1:0]     exc_kind,
    output logic [XLEN-1:0]       lr_data,
    output logic [XLEN-1:0]       spsr_data,
    output logic [XLEN-1:0]       new_psr,
    output logic [XLEN-1:0]       new_pc
);
    logic            take;
    exc_src_e        winner;
    logic [XLEN-1:0] psr_next;
    exc_entry_t      nxt_q, ent_q;
    logic            vld_q;

    exc_seq_arb u_arb (
        .req     (exc_req),
        .irq_off (cur_psr[PSR_I_BIT]),
        .fiq_off (cur_psr[PSR_F_BIT]),
        .hit     (take),
        .win     (winner)
    );

    exc_seq_psr u_psr (
        .old_psr (cur_psr),
        .src     (winner),
        .upd_psr (psr_next)
    );

    always_comb begin
        nxt_q.lr   = ret_pc;
        nxt_q.spsr = cur_psr;
        nxt_q.psr  = psr_next;
        nxt_q.pc   = vector_of(winner);
        nxt_q.src  = winner;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            ent_q <= '0;
        end else begin
            vld_q <= take;
            if (take) ent_q <= nxt_q;
        end
    end

    assign wr_valid  = vld_q;
    assign exc_kind  = ent_q.src;
    assign lr_data   = ent_q.lr;
    assign spsr_data = ent_q.spsr;
    assign new_psr   = ent_q.psr;
    assign new_pc    = ent_q.pc;
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk
    import exc_seq_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic [NUM_SRC-1:0]    exc_req,
    input logic [XLEN-1:0]       ret_pc,
    input logic [XLEN-1:0]       cur_psr,
    input logic                  wr_valid,
    input logic [KIND_W-1:0]     exc_kind,
    input logic [XLEN-1:0]       lr_data,
    input logic [XLEN-1:0]       spsr_data,
    input logic [XLEN-1:0]       new_psr,
    input logic [XLEN-1:0]       new_pc
);
    a_r1_valid_after_req: assert property (@(posedge clk) disable iff (rst)
        (exc_req[0] || exc_req[4]) |=> wr_valid);

    a_r2_link_value: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> lr_data == $past(ret_pc));

    a_r3_saved_status: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> spsr_data == $past(cur_psr));

    a_r4_state_bits: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (!new_psr[PSR_T_BIT] && !new_psr[PSR_J_BIT] && new_psr[PSR_I_BIT]));

    a_r6_r7_irq_entry: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && exc_kind == 3'd5) |-> (new_pc == 32'h18 && new_psr[4:0] == 5'b10010));

    a_r9_irq_masked: assert property (@(posedge clk) disable iff (rst)
        (exc_req == 7'b010_0000 && cur_psr[PSR_I_BIT]) |=> !wr_valid);

    a_r10_fiq_masked: assert property (@(posedge clk) disable iff (rst)
        (exc_req == 7'b100_0000 && cur_psr[PSR_F_BIT]) |=> !wr_valid);

    a_r11_reset_clears: assert property (@(posedge clk)
        rst |=> (!wr_valid && new_pc == '0 && lr_data == '0));
endmodule

bind exc_entry_seq exc_entry_seq_chk u_chk (.*);

// File: tb/exc_entry_seq_tb.sv
module exc_entry_seq_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  exc_req = '0;
    logic [31:0] ret_pc = '0;
    logic [31:0] cur_psr = '0;
    logic        wr_valid;
    logic [2:0]  exc_kind;
    logic [31:0] lr_data, spsr_data, new_psr, new_pc;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    exc_entry_seq u_dut (
        .clk(clk), .rst(rst), .exc_req(exc_req), .ret_pc(ret_pc),
        .cur_psr(cur_psr), .wr_valid(wr_valid), .exc_kind(exc_kind),
        .lr_data(lr_data), .spsr_data(spsr_data), .new_psr(new_psr),
        .new_pc(new_pc)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Independent model of the requirements.
    function automatic int pick(input logic [6:0] r, input logic [31:0] psr);
        logic [6:0] m;
        m = r;
        if (psr[7]) m[5] = 1'b0;   // R9
        if (psr[6]) m[6] = 1'b0;   // R10
        if (m[0]) return 0;        // R8 order
        if (m[4]) return 4;
        if (m[6]) return 6;
        if (m[5]) return 5;
        if (m[3]) return 3;
        if (m[1]) return 1;
        if (m[2]) return 2;
        return -1;
    endfunction

    function automatic logic [31:0] vec(input int k);
        case (k)
            0: return 32'h00; 1: return 32'h04; 2: return 32'h08; 3: return 32'h0C;
            4: return 32'h10; 5: return 32'h18; default: return 32'h1C;
        endcase
    endfunction

    function automatic logic [4:0] md(input int k);
        case (k)
            6: return 5'b10001; 5: return 5'b10010;
            3, 4: return 5'b10111; 1: return 5'b11011;
            default: return 5'b10011;
        endcase
    endfunction

    task automatic take(input string name, input logic [6:0] r,
                        input logic [31:0] pc, input logic [31:0] psr);
        int k;
        logic [31:0] ep;
        @(negedge clk);
        exc_req = r; ret_pc = pc; cur_psr = psr;
        @(negedge clk);
        exc_req = '0;
        k = pick(r, psr);
        if (k < 0) begin
            chk({name, " R9/R10/R1 no write"}, {31'd0, wr_valid}, 32'd0);
            return;
        end
        ep = psr;
        ep[5] = 1'b0; ep[24] = 1'b0; ep[7] = 1'b1;
        if (k == 0 || k == 6) ep[6] = 1'b1;
        ep[4:0] = md(k);
        chk({name, " R1 valid"}, {31'd0, wr_valid}, 32'd1);
        chk({name, " R1/R8 kind"}, {29'd0, exc_kind}, k);
        chk({name, " R2 lr"}, lr_data, pc);
        chk({name, " R3 spsr"}, spsr_data, psr);
        chk({name, " R4/R5/R7 psr"}, new_psr, ep);
        chk({name, " R6 pc"}, new_pc, vec(k));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R11 valid", {31'd0, wr_valid}, 32'd0);
        chk("R11 pc", new_pc, 32'd0);
        chk("R11 psr", new_psr, 32'd0);
        chk("R11 lr", lr_data, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_singles;
        for (int i = 0; i < 7; i++)
            take("single", 7'(1 << i), 32'h8000 + 32'(i * 4), 32'h0100_0030 | 32'(i << 8));
        take("R5 F kept", 7'b000_0010, 32'h1234, 32'h0000_0050);
    endtask

    task automatic t_priority;
        take("R8 all", 7'h7F, 32'hA0, 32'h10);
        take("R8 dabt>fiq", 7'b101_0000, 32'hA4, 32'h10);
        take("R8 fiq>irq", 7'b110_0000, 32'hA8, 32'h10);
        take("R8 irq>pabt", 7'b010_1000, 32'hAC, 32'h10);
        take("R8 pabt>und", 7'b000_1010, 32'hB0, 32'h10);
        take("R8 und>svc", 7'b000_0110, 32'hB4, 32'h10);
    endtask

    task automatic t_mask;
        take("R9 irq off", 7'b010_0000, 32'hC0, 32'h80);
        take("R9 skip to pabt", 7'b010_1000, 32'hC4, 32'h80);
        take("R10 fiq off", 7'b100_0000, 32'hC8, 32'h40);
        take("R10 skip to irq", 7'b110_0000, 32'hCC, 32'h40);
        take("R10 both off", 7'b110_0000, 32'hD0, 32'hC0);
        take("R11 reset unmasked", 7'b000_0001, 32'hD4, 32'hC0);
    endtask

    initial begin
        t_reset();
        t_singles();
        t_priority();
        t_mask();
        t_reset();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule